// File: doc/BRIEF.md
# Shared-Buffer Pointer Queue Manager

This block owns one shared memory of fixed-size cell slots and the linked lists that thread through it. A cell is written once into a free slot when it arrives and is read from that same slot when it leaves. Between those two events only its slot number moves. The slot number is linked into one of several logical queues. There is a ready queue for every pair of output and priority, one multicast ready queue per priority, and one creditless list per flow group for connections under credit flow control. The free slots form one more linked list in the same next-pointer memory.

Every operation takes the head slot off one list and appends it to the tail of another list. An enqueue moves a slot from the free list to its destination queue. A dequeue moves a slot from a ready queue back to the free list. A credit move takes the oldest slot of a named flow group and appends it to the ready queue recorded for that cell. The block carries out at most one such operation per clock. Each request is answered combinationally in the cycle it is presented, and the lists update on the following rising edge. Scheduling, credit accounting and the links are handled by the surrounding logic.

Top module: `pqm_queue_mgr`

## Requirements
- R1: After reset all 64 slots are free: `free_cnt` is 64, `enq_full` is 0, and every queue is empty.
- R2: An accepted enqueue writes the cell into the slot reported on `enq_slot`. The later dequeue of that cell returns the same data and reports the same slot on `deq_slot`. After reset, slots are handed out in ascending address order starting at 0.
- R3: Cells leave a queue in the order they entered it.
- R4: Each output/priority pair (output 0..3, priority 0..2, 0 highest) has its own ready queue. A cell never appears on another output's or another priority's queue.
- R5: With `enq_mc`=1 a cell joins the multicast queue of its priority, whatever `enq_port` says. It is dequeued only with `deq_mc`=1 and the same priority.
- R6: With `enq_bp`=1 a cell joins the creditless list of flow group `enq_fg`. It stays invisible on its ready queue until it is moved.
- R7: A move request (`mv_req`, `mv_fg`) takes the oldest cell of that flow group and appends it to the tail of the ready queue named at its enqueue. If the group is empty, `mv_done` is 0 and nothing changes.
- R8: A dequeue from an empty queue gives `deq_valid`=0 and leaves every queue and `free_cnt` unchanged.
- R9: When no slot is free, `enq_full` is 1 and an enqueue is refused (`enq_ok`=0). A slot freed by a dequeue can be handed out again.
- R10: At most one operation runs per cycle. A dequeue that can succeed wins over a move that can succeed, and that move wins over an enqueue. The losing requests are ignored.
- R11: A priority value of 3 is invalid. An enqueue with it is refused, and a dequeue with it returns `deq_valid`=0.
- R12: `free_cnt` falls by one after each accepted enqueue and rises by one after each dequeue. It is unchanged by a move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_req | input | 1 | Enqueue request |
| enq_data | input | 32 | Cell contents |
| enq_port | input | 2 | Destination output |
| enq_pri | input | 2 | Priority, 0 highest, 3 invalid |
| enq_mc | input | 1 | Cell goes to a multicast queue |
| enq_bp | input | 1 | Cell is flow-controlled and goes to a creditless list |
| enq_fg | input | 2 | Flow group for a flow-controlled cell |
| enq_ok | output | 1 | Enqueue accepted this cycle |
| enq_slot | output | 6 | Slot given to the accepted cell |
| deq_req | input | 1 | Dequeue request |
| deq_port | input | 2 | Output whose queue is read |
| deq_pri | input | 2 | Priority of the queue read |
| deq_mc | input | 1 | Read the multicast queue of `deq_pri` |
| deq_valid | output | 1 | A cell is returned this cycle |
| deq_data | output | 32 | Returned cell |
| deq_slot | output | 6 | Slot the returned cell occupied |
| mv_req | input | 1 | Credit-granted move request |
| mv_fg | input | 2 | Flow group to move from |
| mv_done | output | 1 | Move carried out this cycle |
| free_cnt | output | 7 | Number of free slots |
| enq_full | output | 1 | No free slot |

## Verification
The grant outputs `enq_ok`, `enq_slot`, `deq_valid`, `deq_data`, `deq_slot` and `mv_done` are combinational. They are due in the same cycle as the request, so the bench drives each request just after a falling edge and samples these outputs a quarter period later, before the rising edge that commits the operation. `free_cnt`, `enq_full` and the contents of every queue change only at that rising edge. They are therefore checked in a later cycle: `free_cnt` and `enq_full` are sampled in an idle cycle, and queue contents through later dequeues. A scoreboard holds one expected result per dequeue request and compares it in the sampling slot of that same cycle.

// File: rtl/pqm_pkg.sv
package pqm_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_DEQ  = 2'd1,
      OP_MOVE = 2'd2,
      OP_ENQ  = 2'd3
   } pqm_op_e;

   // queue numbering: 0 free list, then unicast, multicast, creditless
   function automatic int uc_qid(int port, int pri, int npri);
      return 1 + port * npri + pri;
   endfunction

   function automatic int mc_qid(int pri, int nout, int npri);
      return 1 + nout * npri + pri;
   endfunction

   function automatic int cl_qid(int fg, int nout, int npri);
      return 1 + nout * npri + npri + fg;
   endfunction

endpackage

// File: rtl/pqm_cell_store.sv
module pqm_cell_store #(
   parameter int SLOTS  = 64,
   parameter int CELL_W = 32,
   parameter int SW     = 6,
   parameter int QW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SW-1:0]     wr_slot,
   input  logic [CELL_W-1:0] wr_data,
   input  logic [QW-1:0]     wr_tag,
   input  logic              link_en,
   input  logic [SW-1:0]     link_at,
   input  logic [SW-1:0]     link_to,
   input  logic [SW-1:0]     rd_slot,
   output logic [CELL_W-1:0] rd_data,
   output logic [QW-1:0]     rd_tag,
   output logic [SW-1:0]     rd_next
);

   logic [CELL_W-1:0] data_mem [SLOTS];
   logic [QW-1:0]     tag_mem  [SLOTS];
   logic [SLOTS*SW-1:0] next_flat;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         data_mem[wr_slot] <= wr_data;
         tag_mem[wr_slot]  <= wr_tag;
      end
   end

   // next pointers start as one chain 0 -> 1 -> ... -> SLOTS-1
   for (genvar i = 0; i < SLOTS; i++) begin : g_next
      localparam logic [SW-1:0] INIT = SW'((i + 1) % SLOTS);
      logic [SW-1:0] nxt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            nxt <= INIT;
         else if (link_en && link_at == SW'(i))
            nxt <= link_to;
      end
      assign next_flat[i*SW +: SW] = nxt;
   end

   assign rd_data = data_mem[rd_slot];
   assign rd_tag  = tag_mem[rd_slot];
   assign rd_next = next_flat[int'(rd_slot)*SW +: SW];

   // a new link never points a slot at itself
   p_no_self_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
      link_en |-> link_at != link_to);

endmodule

// File: rtl/pqm_queue_table.sv
module pqm_queue_table #(
   parameter int NQ    = 20,
   parameter int SLOTS = 64,
   parameter int SW    = 6,
   parameter int QW    = 5,
   parameter int CW    = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_en,
   input  logic [QW-1:0]   pop_q,
   input  logic [QW-1:0]   push_q,
   input  logic [SW-1:0]   pop_next,
   output logic [SW-1:0]   pop_head,
   output logic [SW-1:0]   push_tail,
   output logic [CW-1:0]   push_cnt,
   output logic [NQ*CW-1:0] cnt_flat
);

   logic [NQ*SW-1:0] head_flat;
   logic [NQ*SW-1:0] tail_flat;

   for (genvar q = 0; q < NQ; q++) begin : g_q
      localparam logic [SW-1:0] T0 = (q == 0) ? SW'(SLOTS - 1) : '0;
      localparam logic [CW-1:0] C0 = (q == 0) ? CW'(SLOTS) : '0;
      logic [SW-1:0] head, tail;
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            head <= '0;
            tail <= T0;
            cnt  <= C0;
         end else if (op_en) begin
            if (pop_q == QW'(q)) begin
               head <= pop_next;
               cnt  <= cnt - 1'b1;
            end
            if (push_q == QW'(q)) begin
               if (cnt == '0)
                  head <= pop_head;
               tail <= pop_head;
               cnt  <= cnt + 1'b1;
            end
         end
      end
      assign head_flat[q*SW +: SW] = head;
      assign tail_flat[q*SW +: SW] = tail;
      assign cnt_flat[q*CW +: CW]  = cnt;
   end

   assign pop_head  = head_flat[int'(pop_q)*SW +: SW];
   assign push_tail = tail_flat[int'(push_q)*SW +: SW];
   assign push_cnt  = cnt_flat[int'(push_q)*CW +: CW];

   logic [CW+4:0] total;
   always_comb begin
      total = '0;
      for (int q = 0; q < NQ; q++)
         total = total + (CW+5)'(cnt_flat[q*CW +: CW]);
   end

   // every slot sits in exactly one list
   p_slots_conserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
      total == (CW+5)'(SLOTS));
   p_distinct_lists_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_en |-> pop_q != push_q);
   p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_en |-> cnt_flat[int'(pop_q)*CW +: CW] != '0);

endmodule

// File: rtl/pqm_op_decode.sv
module pqm_op_decode
   import pqm_pkg::*;
#(
   parameter int NUM_OUT = 4,
   parameter int NUM_PRI = 3,
   parameter int NUM_FG  = 4,
   parameter int NQ      = 20,
   parameter int QW      = 5,
   parameter int CW      = 7,
   parameter int OW      = 2,
   parameter int PW      = 2,
   parameter int FW      = 2
) (
   input  logic            deq_req,
   input  logic [OW-1:0]   deq_port,
   input  logic [PW-1:0]   deq_pri,
   input  logic            deq_mc,
   input  logic            mv_req,
   input  logic [FW-1:0]   mv_fg,
   input  logic            enq_req,
   input  logic [OW-1:0]   enq_port,
   input  logic [PW-1:0]   enq_pri,
   input  logic            enq_mc,
   input  logic            enq_bp,
   input  logic [FW-1:0]   enq_fg,
   input  logic [NQ*CW-1:0] cnt_flat,
   output pqm_op_e         op,
   output logic [QW-1:0]   pop_q,
   output logic [QW-1:0]   push_q,
   output logic [QW-1:0]   enq_tag
);

   function automatic logic [QW-1:0] ready_q(logic [OW-1:0] p, logic [PW-1:0] r, logic mc);
      int v;
      v = mc ? mc_qid(int'(r), NUM_OUT, NUM_PRI) : uc_qid(int'(p), int'(r), NUM_PRI);
      return QW'(v);
   endfunction

   logic [QW-1:0] deq_q, mv_q, enq_dst;
   logic deq_go, mv_go, enq_go;

   always_comb begin
      deq_q   = ready_q(deq_port, deq_pri, deq_mc);
      mv_q    = QW'(cl_qid(int'(mv_fg), NUM_OUT, NUM_PRI));
      enq_tag = ready_q(enq_port, enq_pri, enq_mc);
      enq_dst = enq_bp ? QW'(cl_qid(int'(enq_fg), NUM_OUT, NUM_PRI)) : enq_tag;

      deq_go = deq_req && (int'(deq_pri) < NUM_PRI)
               && (deq_mc || int'(deq_port) < NUM_OUT)
               && (int'(deq_q) < NQ)
               && cnt_flat[int'(deq_q)*CW +: CW] != '0;
      mv_go  = mv_req && (int'(mv_fg) < NUM_FG)
               && cnt_flat[int'(mv_q)*CW +: CW] != '0;
      enq_go = enq_req && (int'(enq_pri) < NUM_PRI)
               && (enq_mc || int'(enq_port) < NUM_OUT)
               && (!enq_bp || int'(enq_fg) < NUM_FG)
               && cnt_flat[0 +: CW] != '0;

      op     = OP_IDLE;
      pop_q  = '0;
      push_q = '0;
      if (deq_go) begin
         op    = OP_DEQ;
         pop_q = deq_q;
      end else if (mv_go) begin
         op    = OP_MOVE;
         pop_q = mv_q;
      end else if (enq_go) begin
         op     = OP_ENQ;
         push_q = enq_dst;
      end
   end

endmodule

// File: rtl/pqm_queue_mgr.sv
module pqm_queue_mgr
   import pqm_pkg::*;
#(
   parameter int NUM_OUT = 4,
   parameter int NUM_PRI = 3,
   parameter int NUM_FG  = 4,
   parameter int SLOTS   = 64,
   parameter int CELL_W  = 32,
   localparam int OW = $clog2(NUM_OUT),
   localparam int PW = $clog2(NUM_PRI),
   localparam int FW = $clog2(NUM_FG),
   localparam int SW = $clog2(SLOTS),
   localparam int CW = $clog2(SLOTS + 1),
   localparam int NQ = 1 + NUM_OUT * NUM_PRI + NUM_PRI + NUM_FG,
   localparam int QW = $clog2(NQ)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_req,
   input  logic [CELL_W-1:0] enq_data,
   input  logic [OW-1:0]     enq_port,
   input  logic [PW-1:0]     enq_pri,
   input  logic              enq_mc,
   input  logic              enq_bp,
   input  logic [FW-1:0]     enq_fg,
   output logic              enq_ok,
   output logic [SW-1:0]     enq_slot,
   input  logic              deq_req,
   input  logic [OW-1:0]     deq_port,
   input  logic [PW-1:0]     deq_pri,
   input  logic              deq_mc,
   output logic              deq_valid,
   output logic [CELL_W-1:0] deq_data,
   output logic [SW-1:0]     deq_slot,
   input  logic              mv_req,
   input  logic [FW-1:0]     mv_fg,
   output logic              mv_done,
   output logic [CW-1:0]     free_cnt,
   output logic              enq_full
);

   if (NUM_OUT < 2 || NUM_PRI < 2 || NUM_FG < 2 || SLOTS < 2 || CELL_W < 1) begin : g_bad_cfg
      $error("pqm_queue_mgr: outputs, priorities, flow groups and slots must each be at least 2");
   end

   pqm_op_e          op;
   logic             op_en;
   logic [QW-1:0]    pop_q, dec_push_q, push_q, enq_tag, rd_tag;
   logic [SW-1:0]    pop_head, push_tail, rd_next;
   logic [CW-1:0]    push_cnt;
   logic [NQ*CW-1:0] cnt_flat;
   logic [CELL_W-1:0] rd_data;

   pqm_op_decode #(
      .NUM_OUT(NUM_OUT), .NUM_PRI(NUM_PRI), .NUM_FG(NUM_FG), .NQ(NQ),
      .QW(QW), .CW(CW), .OW(OW), .PW(PW), .FW(FW)
   ) u_dec (
      .deq_req(deq_req), .deq_port(deq_port), .deq_pri(deq_pri), .deq_mc(deq_mc),
      .mv_req(mv_req), .mv_fg(mv_fg),
      .enq_req(enq_req), .enq_port(enq_port), .enq_pri(enq_pri), .enq_mc(enq_mc),
      .enq_bp(enq_bp), .enq_fg(enq_fg),
      .cnt_flat(cnt_flat),
      .op(op), .pop_q(pop_q), .push_q(dec_push_q), .enq_tag(enq_tag)
   );

   // a moved cell goes where its enqueue tag says
   assign push_q = (op == OP_MOVE) ? rd_tag : dec_push_q;
   assign op_en  = (op != OP_IDLE);

   pqm_queue_table #(
      .NQ(NQ), .SLOTS(SLOTS), .SW(SW), .QW(QW), .CW(CW)
   ) u_tab (
      .clk(clk), .rst_n(rst_n), .op_en(op_en),
      .pop_q(pop_q), .push_q(push_q), .pop_next(rd_next),
      .pop_head(pop_head), .push_tail(push_tail), .push_cnt(push_cnt),
      .cnt_flat(cnt_flat)
   );

   pqm_cell_store #(
      .SLOTS(SLOTS), .CELL_W(CELL_W), .SW(SW), .QW(QW)
   ) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_en(op == OP_ENQ), .wr_slot(pop_head), .wr_data(enq_data), .wr_tag(enq_tag),
      .link_en(op_en && push_cnt != '0), .link_at(push_tail), .link_to(pop_head),
      .rd_slot(pop_head), .rd_data(rd_data), .rd_tag(rd_tag), .rd_next(rd_next)
   );

   assign enq_ok    = (op == OP_ENQ);
   assign enq_slot  = pop_head;
   assign deq_valid = (op == OP_DEQ);
   assign deq_data  = rd_data;
   assign deq_slot  = pop_head;
   assign mv_done   = (op == OP_MOVE);
   assign free_cnt  = cnt_flat[0 +: CW];
   assign enq_full  = (free_cnt == '0);

   p_enq_takes_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      enq_ok |=> free_cnt == $past(free_cnt) - 1'b1);
   p_deq_frees_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      deq_valid |=> free_cnt == $past(free_cnt) + 1'b1);
   p_move_keeps_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mv_done |=> $stable(free_cnt));
   p_idle_keeps_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(enq_ok || deq_valid || mv_done) |=> $stable(free_cnt));
   p_full_refuses_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (free_cnt == '0) |-> !enq_ok);
   p_bad_pri_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_req && int'(deq_pri) >= NUM_PRI) |-> !deq_valid);
   p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({enq_ok, deq_valid, mv_done}));

endmodule

// File: tb/pqm_queue_mgr_test.sv
module pqm_queue_mgr_test;

   localparam int NO = 4, NP = 3, NF = 4, NS = 64, DW = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n;
   logic enq_req, enq_mc, enq_bp, enq_ok, deq_req, deq_mc, deq_valid, mv_req, mv_done, enq_full;
   logic [DW-1:0] enq_data, deq_data;
   logic [1:0] enq_port, enq_pri, enq_fg, deq_port, deq_pri, mv_fg;
   logic [5:0] enq_slot, deq_slot;
   logic [6:0] free_cnt;

   pqm_queue_mgr uut (
      .clk(clk), .rst_n(rst_n),
      .enq_req(enq_req), .enq_data(enq_data), .enq_port(enq_port), .enq_pri(enq_pri),
      .enq_mc(enq_mc), .enq_bp(enq_bp), .enq_fg(enq_fg), .enq_ok(enq_ok), .enq_slot(enq_slot),
      .deq_req(deq_req), .deq_port(deq_port), .deq_pri(deq_pri), .deq_mc(deq_mc),
      .deq_valid(deq_valid), .deq_data(deq_data), .deq_slot(deq_slot),
      .mv_req(mv_req), .mv_fg(mv_fg), .mv_done(mv_done),
      .free_cnt(free_cnt), .enq_full(enq_full)
   );

   typedef struct packed { logic [DW-1:0] d; logic [5:0] s; } cell_t;
   typedef struct packed { logic [DW-1:0] d; logic [5:0] s; logic mc; logic [1:0] o; logic [1:0] p; } pend_t;
   typedef struct packed { logic v; logic [DW-1:0] d; logic [5:0] s; } exp_t;

   cell_t uq [NO*NP][$];
   cell_t mq [NP][$];
   pend_t cq [NF][$];
   exp_t  exp_q [$];
   string rq_q [$];

   int errors = 0, checks = 0, freecnt = NS;
   logic [5:0] last_freed, s;
   bit done = 0;

   task automatic chk(string rq, string what, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      enq_req = 0; enq_data = '0; enq_port = '0; enq_pri = '0; enq_mc = 0; enq_bp = 0; enq_fg = '0;
      deq_req = 0; deq_port = '0; deq_pri = '0; deq_mc = 0;
      mv_req = 0; mv_fg = '0;
   endtask

   function automatic void model_move(int fg);
      pend_t m;
      m = cq[fg].pop_front();
      if (m.mc) mq[m.p].push_back(cell_t'{m.d, m.s});
      else      uq[int'(m.o)*NP + int'(m.p)].push_back(cell_t'{m.d, m.s});
   endfunction

   function automatic void model_enq(logic [DW-1:0] d, logic [5:0] sl, int o, int p, logic mc, logic bp, int fg);
      if (bp)      cq[fg].push_back(pend_t'{d, sl, mc, 2'(o), 2'(p)});
      else if (mc) mq[p].push_back(cell_t'{d, sl});
      else         uq[o*NP + p].push_back(cell_t'{d, sl});
      freecnt--;
   endfunction

   // driver: expected result goes to the scoreboard, monitor compares
   task automatic do_deq(string rq, int o, int p, logic mc);
      cell_t e;
      @(negedge clk);
      idle_inputs();
      deq_req = 1; deq_port = 2'(o); deq_pri = 2'(p); deq_mc = mc;
      if (p < NP && (mc ? mq[p].size() > 0 : uq[o*NP + p].size() > 0)) begin
         e = mc ? mq[p].pop_front() : uq[o*NP + p].pop_front();
         exp_q.push_back(exp_t'{1'b1, e.d, e.s});
         last_freed = e.s;
         freecnt++;
      end else
         exp_q.push_back(exp_t'{1'b0, {DW{1'b0}}, 6'd0});
      rq_q.push_back(rq);
   endtask

   task automatic do_enq(string rq, logic [DW-1:0] d, int o, int p, logic mc, logic bp, int fg, output logic [5:0] got);
      logic exp_ok;
      @(negedge clk);
      idle_inputs();
      enq_req = 1; enq_data = d; enq_port = 2'(o); enq_pri = 2'(p); enq_mc = mc; enq_bp = bp; enq_fg = 2'(fg);
      exp_ok = (freecnt > 0) && (p < NP);
      #5;
      chk(rq, "enq_ok", enq_ok, exp_ok);
      got = enq_slot;
      if (enq_ok && exp_ok) model_enq(d, enq_slot, o, p, mc, bp, fg);
   endtask

   task automatic do_move(string rq, int fg);
      logic exp_mv;
      @(negedge clk);
      idle_inputs();
      mv_req = 1; mv_fg = 2'(fg);
      exp_mv = cq[fg].size() > 0;
      #5;
      chk(rq, "mv_done", mv_done, exp_mv);
      if (exp_mv) model_move(fg);
   endtask

   // dequeue unicast (dq_o,dq_p), move fg, enqueue unicast (eo,ep) all at once
   task automatic do_combo(string rq, int dq_o, int dq_p, int fg, logic [DW-1:0] d, int eo, int ep);
      logic has_d, has_m, exp_e;
      cell_t e;
      @(negedge clk);
      idle_inputs();
      deq_req = 1; deq_port = 2'(dq_o); deq_pri = 2'(dq_p);
      mv_req = 1; mv_fg = 2'(fg);
      enq_req = 1; enq_data = d; enq_port = 2'(eo); enq_pri = 2'(ep);
      has_d = uq[dq_o*NP + dq_p].size() > 0;
      has_m = cq[fg].size() > 0;
      exp_e = !has_d && !has_m && freecnt > 0;
      if (has_d) begin
         e = uq[dq_o*NP + dq_p].pop_front();
         exp_q.push_back(exp_t'{1'b1, e.d, e.s});
         freecnt++;
      end else
         exp_q.push_back(exp_t'{1'b0, {DW{1'b0}}, 6'd0});
      rq_q.push_back(rq);
      #5;
      chk(rq, "mv_done", mv_done, !has_d && has_m);
      chk(rq, "enq_ok", enq_ok, exp_e);
      if (!has_d && has_m) model_move(fg);
      if (exp_e && enq_ok) model_enq(d, enq_slot, eo, ep, 1'b0, 1'b0, 0);
   endtask

   task automatic chk_free(string rq);
      @(negedge clk);
      idle_inputs();
      #5;
      chk(rq, "free_cnt", free_cnt, freecnt);
      chk(rq, "enq_full", enq_full, freecnt == 0);
   endtask

   // monitor: compares dequeue responses in the cycle they are requested
   initial begin
      exp_t e;
      string rq;
      forever begin
         @(negedge clk);
         #5;
         if (deq_req && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            rq = rq_q.pop_front();
            chk(rq, "deq_valid", deq_valid, e.v);
            if (e.v) begin
               chk(rq, "deq_data", deq_data, e.d);
               chk(rq, "deq_slot", deq_slot, e.s);
            end
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      idle_inputs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R1 reset state
      chk_free("R1");
      do_deq("R1 R8", 0, 0, 0);

      // R2 slot order and identity, R3 order, R4 separation
      do_enq("R2", 32'hA1, 1, 0, 0, 0, 0, s); chk("R2", "first slot", s, 0);
      do_enq("R2", 32'hA2, 1, 0, 0, 0, 0, s); chk("R2", "second slot", s, 1);
      do_enq("R3", 32'hA3, 1, 0, 0, 0, 0, s);
      do_enq("R4", 32'hB1, 1, 1, 0, 0, 0, s);
      do_enq("R4", 32'hC1, 2, 0, 0, 0, 0, s);
      chk_free("R12");
      do_deq("R4", 2, 0, 0);
      do_deq("R4", 1, 1, 0);
      do_deq("R4", 2, 0, 0);
      do_deq("R3", 1, 0, 0);
      do_deq("R3", 1, 0, 0);
      do_deq("R3", 1, 0, 0);
      do_deq("R8", 1, 0, 0);
      chk_free("R8 R12");

      // R5 multicast queues
      do_enq("R5", 32'hD1, 3, 2, 1, 0, 0, s);
      do_enq("R5", 32'hD2, 0, 2, 1, 0, 0, s);
      do_deq("R5", 3, 2, 0);
      do_deq("R5", 1, 2, 1);
      do_deq("R5", 0, 2, 1);
      do_deq("R5", 0, 1, 1);

      // R6 creditless lists, R7 moves
      do_enq("R6", 32'hE1, 0, 1, 0, 1, 1, s);
      do_enq("R6", 32'hE2, 0, 1, 0, 1, 1, s);
      do_enq("R6", 32'hE3, 0, 0, 1, 1, 2, s);
      do_enq("R6", 32'hE4, 0, 1, 0, 0, 0, s);
      do_deq("R6", 0, 1, 0);
      do_deq("R6", 0, 1, 0);
      do_deq("R6", 0, 0, 1);
      do_move("R7", 1);
      do_enq("R7", 32'hE5, 0, 1, 0, 0, 0, s);
      do_move("R7", 1);
      do_move("R7", 3);
      chk_free("R7 R12");
      do_deq("R7", 0, 1, 0);
      do_deq("R7", 0, 1, 0);
      do_deq("R7", 0, 1, 0);
      do_move("R7", 2);
      do_deq("R7", 0, 0, 1);

      // R10 arbitration between simultaneous requests
      do_enq("R10", 32'hF1, 2, 2, 0, 0, 0, s);
      do_enq("R10", 32'hF2, 0, 0, 0, 1, 0, s);
      do_combo("R10", 2, 2, 0, 32'hF3, 3, 0);
      do_combo("R10", 2, 2, 0, 32'hF4, 3, 0);
      do_deq("R10", 3, 0, 0);
      do_deq("R10", 0, 0, 0);
      do_combo("R10", 2, 2, 1, 32'hF5, 3, 0);
      do_deq("R10", 3, 0, 0);

      // R11 invalid priority
      do_enq("R11", 32'h77, 1, 3, 0, 0, 0, s);
      do_enq("R11", 32'h78, 0, 3, 1, 0, 0, s);
      do_deq("R11", 1, 3, 0);
      do_deq("R11", 0, 3, 1);
      chk_free("R11");

      // R9 full buffer and slot reuse
      for (int i = 0; freecnt > 0; i++) do_enq("R9", 32'h1000 + i, 3, 2, 0, 0, 0, s);
      chk_free("R9");
      do_enq("R9", 32'h2000, 1, 0, 0, 0, 0, s);
      do_deq("R9", 3, 2, 0);
      chk_free("R9");
      do_enq("R9", 32'h3000, 3, 2, 0, 0, 0, s);
      chk("R9", "reused slot", s, last_freed);
      while (uq[3*NP + 2].size() > 0) do_deq("R9", 3, 2, 0);
      chk_free("R9 R12");

      repeat (2) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule